// File: doc/BRIEF.md
# System Glue Register Block

This block is a small bus slave that collects a handful of system services behind one 32-byte register window. Firmware uses it to end a run with an exit code, to learn which processor it runs on and how many processors are present, to raise or drop the level-sensitive external interrupt line of any processor, and to move single characters to and from a console.

The bus is a simple synchronous one. A request is a single-cycle `bus_valid`, with a byte address, four byte enables, 32-bit write data and the identifier of the requesting processor. Each read returns registered data one cycle later, with `bus_rvalid` high for that cycle. Every register lives in byte lane 0 of its 32-bit word. The one exception is the interrupt word, which also uses lane 1.

The console input side is a one-entry buffer. It is filled from a character stream (`in_valid`/`in_char`, acknowledged by `in_ack`) when software polls its status while the buffer is empty. The console output side pulses `out_strobe` with the character on every data write.

Top module: `sys_glue_regs`

## Requirements
- R1: After reset, output status reads 1, output data reads 0, input data reads 0 and input status reads 0 (while no character is offered). All interrupt lines are low and `halt_req` is low.
- R2: Only address bits [4:2] select a register. The window repeats every 32 bytes, and bits [1:0] and all bits above bit 4 are ignored.
- R3: A write to word 0 (offset 0) with lane 0 enabled raises `halt_req` for exactly one cycle after the write edge. On that write, `exit_code` takes write data bits [7:0] and holds them.
- R4: A read of word 1 (offset 4) returns `bus_req_id`. A read of word 3 (offset 12) returns the parameter NUM_CPU.
- R5: A write to word 2 (offset 8) takes lane 0 (bits [7:0]) as the port number. If lane 1 is also enabled, lane 1 (bits [15:8]) is the level, and the line is driven high when that level is nonzero and low when it is zero. If lane 1 is not enabled, the line is driven low. A port number of NUM_CPU or more changes nothing, and lines other than the addressed one keep their value.
- R6: A read of word 5 (offset 20) while input status is zero scans the stream. If `in_valid` is high, then `in_ack` is high in that cycle, the buffer takes `in_char` and status becomes 1. If `in_valid` is low, buffer and status are both cleared. The read returns the status after the scan. While status is nonzero, a status read returns it unchanged without scanning. Reads of word 4 (offset 16) return the buffer without clearing it.
- R7: A write to word 6 (offset 24) pulses `out_strobe` for one cycle with `out_char` equal to bits [7:0], and sets output status to 1. Reads of word 6 return the last character written.
- R8: Writes to word 4 (input data), word 5 (input status) and word 7 (output status) overwrite those 8-bit registers directly.
- R9: A read returns its 8-bit value in bits [7:0], with bits [31:8] zero, and `bus_rvalid` high one cycle after the request. Reads of words 0 and 2 return 0, and writes to words 1 and 3 change nothing.
- R10: A write with byte enable bit 0 clear changes no register and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables, bit i for bits [8i+7:8i] |
| bus_wdata | input | 32 | Write data |
| bus_req_id | input | ID_W | Index of the requesting processor |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| irq_out | output | NUM_CPU | Level interrupt line per processor |
| halt_req | output | 1 | One-cycle halt request |
| exit_code | output | 8 | Exit code of the last halt write |
| in_valid | input | 1 | A console character is offered |
| in_char | input | 8 | Offered console character |
| in_ack | output | 1 | Offered character taken this cycle |
| out_strobe | output | 1 | Output character valid, one cycle |
| out_char | output | 8 | Last character written out |

## Verification
The interrupt word is driven with full two-lane writes at nonzero and zero levels, a lane-0-only write, an out-of-range port and a write missing lane 0. Between them, these tell apart level decoding, the single-byte default, range checking and the lane-0 gate. Input status is polled with a character offered and absent, both while the buffer is empty and while it is full, to separate scanning from holding. Processor-ID reads use different requester IDs and an aliased address, to show that the value follows the request and not the address bits above bit 4.

// File: rtl/sys_glue_regs.sv
module sys_glue_regs #(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 16,
  parameter int ID_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic [ID_W-1:0]   bus_req_id,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [NUM_CPU-1:0] irq_out,
  output logic              halt_req,
  output logic [7:0]        exit_code,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  output logic              in_ack,
  output logic              out_strobe,
  output logic [7:0]        out_char
);
  localparam logic [2:0] W_HALT = 3'd0, W_ID = 3'd1, W_IRQ = 3'd2, W_CNT = 3'd3,
                         W_IDAT = 3'd4, W_ISTAT = 3'd5, W_ODAT = 3'd6, W_OSTAT = 3'd7;

  logic [2:0] word;
  logic       rd, wr, scan, lvl;
  logic [7:0] in_buf, in_stat, out_stat, rd_byte;

  assign word   = bus_addr[4:2];
  assign rd     = bus_valid & ~bus_write;
  assign wr     = bus_valid & bus_write & bus_be[0];
  assign scan   = rd && word == W_ISTAT && in_stat == 8'd0;
  assign in_ack = scan & in_valid;
  assign lvl    = bus_be[1] & (|bus_wdata[15:8]);

  always_comb begin
    case (word)
      W_ID:    rd_byte = {{(8-ID_W){1'b0}}, bus_req_id};
      W_CNT:   rd_byte = 8'(NUM_CPU);
      W_IDAT:  rd_byte = in_buf;
      W_ISTAT: rd_byte = (in_stat != 8'd0) ? in_stat : {7'd0, in_valid};
      W_ODAT:  rd_byte = out_char;
      W_OSTAT: rd_byte = out_stat;
      default: rd_byte = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq_out    <= '0;
      halt_req   <= 1'b0;
      exit_code  <= 8'd0;
      out_strobe <= 1'b0;
      out_char   <= 8'd0;
      out_stat   <= 8'd1;
      in_buf     <= 8'd0;
      in_stat    <= 8'd0;
    end else begin
      halt_req   <= 1'b0;
      out_strobe <= 1'b0;
      bus_rvalid <= rd;
      bus_rdata  <= rd ? {24'd0, rd_byte} : 32'd0;
      if (scan) begin
        in_buf  <= in_valid ? in_char : 8'd0;
        in_stat <= {7'd0, in_valid};
      end
      if (wr) begin
        case (word)
          W_HALT: begin
            halt_req  <= 1'b1;
            exit_code <= bus_wdata[7:0];
          end
          W_IRQ: begin
            for (int k = 0; k < NUM_CPU; k++)
              if (bus_wdata[7:0] == 8'(k)) irq_out[k] <= lvl;
          end
          W_IDAT:  in_buf  <= bus_wdata[7:0];
          W_ISTAT: in_stat <= bus_wdata[7:0];
          W_ODAT: begin
            out_char   <= bus_wdata[7:0];
            out_strobe <= 1'b1;
            out_stat   <= 8'd1;
          end
          W_OSTAT: out_stat <= bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sys_glue_regs_chk.sv
module sys_glue_regs_chk #(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 16,
  parameter int ID_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [NUM_CPU-1:0] irq_out,
  input logic              halt_req,
  input logic [7:0]        exit_code,
  input logic              in_ack,
  input logic              out_strobe
);
  a_r3_halt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);
  a_r3_halt_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> exit_code == $past(bus_wdata[7:0]));
  a_r7_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe);
  a_r9_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> bus_rdata[31:8] == 24'd0);
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> $stable(irq_out));
  a_r6_ack_status: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> bus_rvalid && bus_rdata[7:0] == 8'd1);
endmodule

bind sys_glue_regs sys_glue_regs_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .ID_W(ID_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .irq_out(irq_out), .halt_req(halt_req), .exit_code(exit_code),
  .in_ack(in_ack), .out_strobe(out_strobe));

// File: tb/test_sys_glue_regs.sv
`timescale 1ns/1ps
module test_sys_glue_regs;
  localparam int NCPU = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [15:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_req_id = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, halt_req, in_ack, out_strobe;
  logic [NCPU-1:0] irq_out;
  logic [7:0] exit_code, out_char;
  logic in_valid = 0;
  logic [7:0] in_char = '0;
  int vecs = 0, bad = 0;
  bit done = 0;
  logic ack_seen;
  logic [31:0] rv;

  always #5 clk = ~clk;

  sys_glue_regs #(.NUM_CPU(NCPU), .ADDR_W(16)) i_sys_glue_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_req_id(bus_req_id), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_out(irq_out), .halt_req(halt_req), .exit_code(exit_code),
    .in_valid(in_valid), .in_char(in_char), .in_ack(in_ack),
    .out_strobe(out_strobe), .out_char(out_char));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk); #1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [15:0] a, logic [1:0] id, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = 4'hF; bus_req_id = id;
    #2 ack_seen = in_ack;
    @(posedge clk); #1;
    d = bus_rdata;
    chk("R9 rvalid", {31'd0, bus_rvalid}, 32'd1);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {28'd0, irq_out}, 0);
    chk("R1 halt", {31'd0, halt_req}, 0);
    rd(16'd28, 0, rv); chk("R1 out status", rv, 1);
    rd(16'd24, 0, rv); chk("R1 out data", rv, 0);
    rd(16'd16, 0, rv); chk("R1 in data", rv, 0);
    rd(16'd20, 0, rv); chk("R1 in status", rv, 0);
    rd(16'd0, 0, rv);  chk("R9 halt word reads 0", rv, 0);
  endtask

  task automatic t_ids;
    rd(16'd4, 0, rv); chk("R4 id 0", rv, 0);
    rd(16'd4, 3, rv); chk("R4 id 3", rv, 3);
    rd(16'd12, 1, rv); chk("R4 count", rv, NCPU);
    rd(16'h0124, 2, rv); chk("R2 alias id", rv, 2);
    rd(16'h004F, 1, rv); chk("R2 alias count", rv, NCPU);
    wr(16'd4, 4'hF, 32'hFF); rd(16'd4, 1, rv); chk("R9 id write ignored", rv, 1);
  endtask

  task automatic t_irq;
    wr(16'd8, 4'b0011, 32'h0102); chk("R5 port2 lvl1", {28'd0, irq_out}, 32'h4);
    wr(16'd8, 4'b0011, 32'h0501); chk("R5 port1 lvl5", {28'd0, irq_out}, 32'h6);
    wr(16'd8, 4'b0001, 32'hFF02); chk("R5 single byte low", {28'd0, irq_out}, 32'h2);
    wr(16'd8, 4'b0011, 32'h0109); chk("R5 port out of range", {28'd0, irq_out}, 32'h2);
    wr(16'd8, 4'b0010, 32'h0001); chk("R10 no lane0", {28'd0, irq_out}, 32'h2);
    wr(16'h0028, 4'b0011, 32'h0100); chk("R2 alias irq", {28'd0, irq_out}, 32'h3);
    wr(16'd8, 4'b0011, 32'h0001); chk("R5 level zero", {28'd0, irq_out}, 32'h1);
    rd(16'd8, 0, rv); chk("R9 irq reads 0", rv, 0);
  endtask

  task automatic t_halt;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 16'd0; bus_be = 4'h1; bus_wdata = 32'h77A5;
    @(posedge clk); #1;
    chk("R3 halt pulse", {31'd0, halt_req}, 1);
    chk("R3 exit code", {24'd0, exit_code}, 32'hA5);
    @(negedge clk); bus_valid = 0; bus_write = 0;
    @(posedge clk); #1;
    chk("R3 halt one cycle", {31'd0, halt_req}, 0);
    wr(16'd0, 4'b1110, 32'h11);
    chk("R10 halt gated", {31'd0, halt_req}, 0);
    chk("R10 exit held", {24'd0, exit_code}, 32'hA5);
  endtask

  task automatic t_input;
    in_valid = 1; in_char = 8'h41;
    rd(16'd20, 0, rv); chk("R6 status scan", rv, 1);
    chk("R6 ack", {31'd0, ack_seen}, 1);
    rd(16'd16, 0, rv); chk("R6 data", rv, 32'h41);
    rd(16'd16, 0, rv); chk("R6 data kept", rv, 32'h41);
    in_char = 8'h42;
    rd(16'd20, 0, rv); chk("R6 full no scan", rv, 1);
    chk("R6 no ack when full", {31'd0, ack_seen}, 0);
    rd(16'd16, 0, rv); chk("R6 data held", rv, 32'h41);
    wr(16'd20, 4'h1, 32'h0);
    in_valid = 0;
    rd(16'd20, 0, rv); chk("R6 empty scan", rv, 0);
    rd(16'd16, 0, rv); chk("R6 buffer cleared", rv, 0);
  endtask

  task automatic t_output;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 16'd24; bus_be = 4'hF; bus_wdata = 32'hFFFF_FF5A;
    @(posedge clk); #1;
    chk("R7 strobe", {31'd0, out_strobe}, 1);
    chk("R7 char", {24'd0, out_char}, 32'h5A);
    @(negedge clk); bus_valid = 0; bus_write = 0;
    @(posedge clk); #1;
    chk("R7 strobe one cycle", {31'd0, out_strobe}, 0);
    rd(16'd24, 0, rv); chk("R7 data readback", rv, 32'h5A);
    wr(16'd28, 4'h1, 32'h0); rd(16'd28, 0, rv); chk("R8 out status write", rv, 0);
    wr(16'd24, 4'h1, 32'h33); rd(16'd28, 0, rv); chk("R7 status set", rv, 1);
    wr(16'd16, 4'h1, 32'h9C); rd(16'd16, 0, rv); chk("R8 in data write", rv, 32'h9C);
    wr(16'd20, 4'h1, 32'h7); rd(16'd20, 0, rv); chk("R8 in status write", rv, 7);
    wr(16'd24, 4'h2, 32'h4400); rd(16'd24, 0, rv); chk("R10 out data gated", rv, 32'h33);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    t_reset;
    t_ids;
    t_irq;
    t_halt;
    t_input;
    t_output;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule